// File: doc/BRIEF.md
# Timer Capture/Compare Channel

One channel of a general-purpose timer. A free-running counter value arrives as an input, and the channel uses it in one of four ways: it latches the counter on an edge of an external pin (input capture), drives a pin level when the counter reaches a stored value (output compare or PWM), or does the same with a compare value that is double-buffered and takes effect only at counter overflow. A 4-bit configuration word selects the mode. It holds a 2-bit mode field and a 2-bit edge/level field. Some codes also define a "preset" state. In that state the pin stays with the general-purpose port, but the channel's output level is already set up for when the channel takes the pin.

Software writes the configuration and the channel value through single-cycle write strobes and reads both back. Any capture or compare event raises a channel flag. A write-one-to-clear strobe drops the flag. The pin output comes with an output-enable. When the output-enable is low, the pin belongs to the general-purpose port.

Top module: `tcc_channel`

## Requirements
- R1: After reset, the configuration reads 0, `flag_o` is 0, `rd_val_o` is 0, `pin_oe_o` is 0 and `pin_o` is 1.
- R2: The configuration word is {mode[1:0], lvl[1:0]} in bits [3:2] and [1:0] of `cfg_wdata_i` and `rd_cfg_o`. When lvl is 00 the channel is in preset. `pin_oe_o` is then 0, and `pin_o` equals the inverse of mode[0] from the cycle after the configuration write.
- R3: Mode 00 with lvl 01, 10 or 11 is input capture on the rising edge, the falling edge, or either edge. The pin passes through two synchronising flops and an edge detector, so the capture happens at the third rising clock edge after the pin changes. At that edge, `rd_val_o` takes the value of `cnt_i` and `flag_o` is set.
- R4: In input capture, `pin_oe_o` is 0, `pin_o` keeps its level, and a counter value that equals the channel value has no effect.
- R5: Mode 01 with lvl 01, 10 or 11 is compare. At a clock edge where `cnt_i` equals the active channel value, lvl 01 toggles `pin_o`, lvl 10 clears it and lvl 11 sets it, and `flag_o` is set at the same edge.
- R6: A mode with mode[1]=1 compares exactly like R5 whatever mode[0] is. In such a mode a value write only loads a shadow register, and `rd_val_o` and the compare use the active value. The shadow value moves to the active value at an edge where `cnt_ovf_i` is 1.
- R7: `pin_oe_o` is 1 exactly when lvl is non-zero and mode is not 00.
- R8: `flag_clr_i` clears `flag_o`. When a capture or match event occurs in the same cycle, the event wins and the flag stays 1.
- R9: On leaving preset for a compare mode, the preset level appears on the pin with `pin_oe_o` high and holds until the first match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | CNT_W | Free-running counter value |
| cnt_ovf_i | input | 1 | Counter overflow pulse |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 4 | Configuration {mode, lvl} |
| val_wr_i | input | 1 | Channel value write strobe |
| val_wdata_i | input | CNT_W | Channel value write data |
| flag_clr_i | input | 1 | Write-one-to-clear for the flag |
| cap_pin_i | input | 1 | Asynchronous capture pin |
| rd_cfg_o | output | 4 | Configuration readback |
| rd_val_o | output | CNT_W | Active channel value readback |
| flag_o | output | 1 | Channel event flag |
| pin_o | output | 1 | Channel pin level |
| pin_oe_o | output | 1 | Channel owns the pin |

## Verification
The bench targets the capture latency. A design with one synchroniser stage too many or too few would latch a counter value one cycle early or late. The bench also drives a flag clear in the same cycle as a match, which a clear-wins flag would lose. Buffered writes are checked so that they stay invisible until the overflow pulse; a design that writes through would move the match point within a period. The preset level is checked across the switch into compare mode, since a design that resets the output there would glitch the pin.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

    typedef struct packed {
        logic [1:0] mode;
        logic [1:0] lvl;
    } chan_cfg_t;

    localparam logic [1:0] LVL_OFF    = 2'b00;
    localparam logic [1:0] LVL_TOGGLE = 2'b01;
    localparam logic [1:0] LVL_CLEAR  = 2'b10;
    localparam logic [1:0] LVL_SET    = 2'b11;

    function automatic logic is_capture(chan_cfg_t c);
        return (c.mode == 2'b00) && (c.lvl != LVL_OFF);
    endfunction

    function automatic logic is_compare(chan_cfg_t c);
        return (c.mode != 2'b00) && (c.lvl != LVL_OFF);
    endfunction

    function automatic logic preset_level(chan_cfg_t c);
        return ~c.mode[0];
    endfunction

endpackage

// File: rtl/tcc_edge_sync.sv
module tcc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    localparam int MSB = STAGES - 1;

    typedef struct packed {
        logic [MSB:0] sh;
        logic         prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.prev = st_q.sh[MSB];
        st_d.sh   = {st_q.sh[MSB-1:0], pin_i};
        rise_o = st_q.sh[MSB] & ~st_q.prev;
        fall_o = ~st_q.sh[MSB] & st_q.prev;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/tcc_val_reg.sv
module tcc_val_reg #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             buffered_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             cap_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             ovf_i,
    output logic [CNT_W-1:0] act_o
);
    typedef struct packed {
        logic [CNT_W-1:0] act;
        logic [CNT_W-1:0] shadow;
        logic             pend;
    } val_st_t;

    val_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cap_i) begin
            st_d.act = cnt_i;
        end else if (buffered_i) begin
            if (ovf_i && st_q.pend) begin
                st_d.act  = st_q.shadow;
                st_d.pend = 1'b0;
            end
            if (wr_i) begin
                st_d.shadow = wdata_i;
                st_d.pend   = 1'b1;
            end
        end else if (wr_i) begin
            st_d.act = wdata_i;
        end
        if (!buffered_i) st_d.pend = 1'b0;
        act_o = st_q.act;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/tcc_out_ctl.sv
module tcc_out_ctl
    import tcc_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic [1:0] cur_lvl_i,
    input  chan_cfg_t nxt_cfg_i,
    input  logic      match_i,
    input  logic      cap_ev_i,
    input  logic      flag_clr_i,
    output logic      out_o,
    output logic      flag_o
);
    typedef struct packed {
        logic out;
        logic flag;
    } out_st_t;

    out_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cap_ev_i || match_i) st_d.flag = 1'b1;
        else if (flag_clr_i)     st_d.flag = 1'b0;

        if (nxt_cfg_i.lvl == LVL_OFF) begin
            st_d.out = preset_level(nxt_cfg_i);
        end else if (match_i) begin
            unique case (cur_lvl_i)
                LVL_TOGGLE: st_d.out = ~st_q.out;
                LVL_CLEAR:  st_d.out = 1'b0;
                LVL_SET:    st_d.out = 1'b1;
                default:    st_d.out = st_q.out;
            endcase
        end
        out_o  = st_q.out;
        flag_o = st_q.flag;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{out: 1'b1, flag: 1'b0};
        else         st_q <= st_d;
    end
endmodule

// File: rtl/tcc_channel.sv
module tcc_channel
    import tcc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             cnt_ovf_i,
    input  logic             cfg_wr_i,
    input  logic [3:0]       cfg_wdata_i,
    input  logic             val_wr_i,
    input  logic [CNT_W-1:0] val_wdata_i,
    input  logic             flag_clr_i,
    input  logic             cap_pin_i,
    output logic [3:0]       rd_cfg_o,
    output logic [CNT_W-1:0] rd_val_o,
    output logic             flag_o,
    output logic             pin_o,
    output logic             pin_oe_o
);
    chan_cfg_t cfg_d, cfg_q;
    logic rise, fall, cap_ev, match;
    logic [CNT_W-1:0] act_val;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_wr_i) cfg_d = chan_cfg_t'(cfg_wdata_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    tcc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .pin_i (cap_pin_i),
        .rise_o(rise),
        .fall_o(fall)
    );

    always_comb begin
        cap_ev = 1'b0;
        if (is_capture(cfg_q)) begin
            unique case (cfg_q.lvl)
                2'b01:   cap_ev = rise;
                2'b10:   cap_ev = fall;
                2'b11:   cap_ev = rise | fall;
                default: cap_ev = 1'b0;
            endcase
        end
        match = is_compare(cfg_q) && (cnt_i == act_val);
    end

    tcc_val_reg #(.CNT_W(CNT_W)) u_val (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .buffered_i(cfg_q.mode[1]),
        .wr_i      (val_wr_i),
        .wdata_i   (val_wdata_i),
        .cap_i     (cap_ev),
        .cnt_i     (cnt_i),
        .ovf_i     (cnt_ovf_i),
        .act_o     (act_val)
    );

    tcc_out_ctl u_out (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .cur_lvl_i (cfg_q.lvl),
        .nxt_cfg_i (cfg_d),
        .match_i   (match),
        .cap_ev_i  (cap_ev),
        .flag_clr_i(flag_clr_i),
        .out_o     (pin_o),
        .flag_o    (flag_o)
    );

    assign rd_cfg_o = cfg_q;
    assign rd_val_o = act_val;
    assign pin_oe_o = is_compare(cfg_q);
endmodule

// File: rtl/tcc_channel_chk.sv
module tcc_channel_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [CNT_W-1:0] cnt_i,
    input logic             cnt_ovf_i,
    input logic             cfg_wr_i,
    input logic             flag_clr_i,
    input logic [3:0]       rd_cfg_o,
    input logic [CNT_W-1:0] rd_val_o,
    input logic             flag_o,
    input logic             pin_o,
    input logic             pin_oe_o
);
    logic cap_m, cmp_m;
    assign cap_m = (rd_cfg_o[3:2] == 2'b00) && (rd_cfg_o[1:0] != 2'b00);
    assign cmp_m = (rd_cfg_o[3:2] != 2'b00) && (rd_cfg_o[1:0] != 2'b00);

    assert_preset_oe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_cfg_o[1:0] == 2'b00) |-> (!pin_oe_o && pin_o == ~rd_cfg_o[2]));

    assert_capture_oe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cap_m |-> !pin_oe_o);

    assert_capture_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cap_m && !cfg_wr_i) |=> $stable(pin_o));

    assert_match_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmp_m && cnt_i == rd_val_o) |=> flag_o);

    assert_buffered_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_cfg_o[3] && !cnt_ovf_i) |=> $stable(rd_val_o));

    assert_compare_oe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmp_m |-> pin_oe_o);

    assert_flag_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_o && !flag_clr_i) |=> flag_o);
endmodule

bind tcc_channel tcc_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_i     (cnt_i),
    .cnt_ovf_i (cnt_ovf_i),
    .cfg_wr_i  (cfg_wr_i),
    .flag_clr_i(flag_clr_i),
    .rd_cfg_o  (rd_cfg_o),
    .rd_val_o  (rd_val_o),
    .flag_o    (flag_o),
    .pin_o     (pin_o),
    .pin_oe_o  (pin_oe_o)
);

// File: tb/tcc_channel_bench.sv
`timescale 1ns/100ps
module tcc_channel_bench;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] cnt = '0;
    logic ovf = 1'b0, cfg_wr = 1'b0, val_wr = 1'b0, clr = 1'b0, pin = 1'b0;
    logic [3:0] cfg_wd = '0;
    logic [W-1:0] val_wd = '0;
    logic [3:0] rd_cfg;
    logic [W-1:0] rd_val;
    logic flag, pout, poe;

    int checks = 0;
    int fails = 0;

    // reference state
    logic [1:0] m_mode, m_lvl;
    logic [W-1:0] m_act, m_shadow;
    logic m_pend, m_out, m_flag, m_s1, m_s2, m_prev;

    always #2.5 clk = ~clk;

    tcc_channel #(.CNT_W(W)) u_tcc_channel (
        .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt), .cnt_ovf_i(ovf),
        .cfg_wr_i(cfg_wr), .cfg_wdata_i(cfg_wd), .val_wr_i(val_wr),
        .val_wdata_i(val_wd), .flag_clr_i(clr), .cap_pin_i(pin),
        .rd_cfg_o(rd_cfg), .rd_val_o(rd_val), .flag_o(flag),
        .pin_o(pout), .pin_oe_o(poe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_oe(input logic [1:0] md, input logic [1:0] lv);
        return (lv != 2'b00) && (md != 2'b00);
    endfunction

    task automatic model_reset();
        m_mode = 0; m_lvl = 0; m_act = 0; m_shadow = 0; m_pend = 0;
        m_out = 1; m_flag = 0; m_s1 = 0; m_s2 = 0; m_prev = 0;
    endtask

    task automatic model_step();
        logic rise, fall, cap_ev, match, capm, cmpm;
        logic [1:0] n_mode, n_lvl;
        rise = m_s2 & ~m_prev;
        fall = ~m_s2 & m_prev;
        capm = (m_mode == 2'b00) && (m_lvl != 2'b00);
        cmpm = exp_oe(m_mode, m_lvl);
        cap_ev = capm && ((m_lvl == 2'b01 && rise) || (m_lvl == 2'b10 && fall) ||
                          (m_lvl == 2'b11 && (rise || fall)));
        match = cmpm && (cnt == m_act);
        n_mode = cfg_wr ? cfg_wd[3:2] : m_mode;
        n_lvl  = cfg_wr ? cfg_wd[1:0] : m_lvl;
        if (n_lvl == 2'b00) m_out = ~n_mode[0];
        else if (match) begin
            if (m_lvl == 2'b01) m_out = ~m_out;
            else if (m_lvl == 2'b10) m_out = 1'b0;
            else m_out = 1'b1;
        end
        if (cap_ev || match) m_flag = 1'b1;
        else if (clr) m_flag = 1'b0;
        if (cap_ev) m_act = cnt;
        else if (m_mode[1]) begin
            if (ovf && m_pend) begin m_act = m_shadow; m_pend = 0; end
            if (val_wr) begin m_shadow = val_wd; m_pend = 1; end
        end else if (val_wr) m_act = val_wd;
        if (!m_mode[1]) m_pend = 0;
        m_prev = m_s2; m_s2 = m_s1; m_s1 = pin;
        m_mode = n_mode; m_lvl = n_lvl;
    endtask

    task automatic compare_all();
        check("R2 config readback", {28'd0, rd_cfg}, {28'd0, m_mode, m_lvl});
        check("R7 output enable", {31'd0, poe}, {31'd0, exp_oe(m_mode, m_lvl)});
        check("R5 pin level", {31'd0, pout}, {31'd0, m_out});
        check("R8 flag", {31'd0, flag}, {31'd0, m_flag});
        check("R6 channel value", {16'd0, rd_val}, {16'd0, m_act});
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        #1;
        compare_all();
        cfg_wr = 0; val_wr = 0; clr = 0; ovf = 0;
    endtask

    task automatic set_cfg(input logic [1:0] md, input logic [1:0] lv);
        cfg_wr = 1; cfg_wd = {md, lv};
        tick();
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        check("R1 cfg", {28'd0, rd_cfg}, 0);
        check("R1 flag", {31'd0, flag}, 0);
        check("R1 value", {16'd0, rd_val}, 0);
        check("R1 oe", {31'd0, poe}, 0);
        check("R1 pin", {31'd0, pout}, 1);

        // R2 preset levels
        set_cfg(2'b01, 2'b00);
        check("R2 preset low", {31'd0, pout}, 0);
        check("R2 preset oe", {31'd0, poe}, 0);
        set_cfg(2'b00, 2'b00);
        check("R2 preset high", {31'd0, pout}, 1);

        // R3 rising capture with two-stage latency
        cnt = 16'h0033;
        set_cfg(2'b00, 2'b01);
        tick(); tick();
        pin = 1;
        tick(); tick();
        check("R3 no capture before sync", {31'd0, flag}, 0);
        tick();
        check("R3 rising capture flag", {31'd0, flag}, 1);
        check("R3 rising capture value", {16'd0, rd_val}, 32'h33);
        check("R4 capture oe", {31'd0, poe}, 0);
        // R4 match has no effect in capture
        clr = 1; tick();
        tick();
        check("R4 match ignored flag", {31'd0, flag}, 0);
        check("R4 pin held", {31'd0, pout}, 1);
        // R3 falling-only mode
        cfg_wr = 1; cfg_wd = 4'b0010; cnt = 16'h0041; tick();
        pin = 0; tick(); tick(); tick();
        check("R3 falling capture value", {16'd0, rd_val}, 32'h41);
        clr = 1; tick();
        pin = 1; tick(); tick(); tick();
        check("R3 rising ignored in falling mode", {31'd0, flag}, 0);

        // R9 preset carried into compare
        set_cfg(2'b01, 2'b00);
        set_cfg(2'b01, 2'b11);
        check("R9 preset level kept", {31'd0, pout}, 0);
        check("R9 oe on", {31'd0, poe}, 1);
        cnt = 9; val_wr = 1; val_wd = 5; tick();
        cnt = 5; tick();
        check("R5 set on match", {31'd0, pout}, 1);
        check("R5 flag on match", {31'd0, flag}, 1);
        clr = 1; tick();
        check("R8 event wins over clear", {31'd0, flag}, 1);
        cnt = 6; clr = 1; tick();
        check("R8 clear", {31'd0, flag}, 0);
        // R5 toggle
        set_cfg(2'b01, 2'b01);
        cnt = 5; tick();
        check("R5 toggle 1", {31'd0, pout}, 0);
        tick();
        check("R5 toggle 2", {31'd0, pout}, 1);

        // R6 buffered, mode[0] ignored
        cnt = 6;
        set_cfg(2'b11, 2'b10);
        val_wr = 1; val_wd = 8; tick();
        check("R6 shadow not visible", {16'd0, rd_val}, 5);
        cnt = 8; tick();
        check("R6 no match on shadow", {31'd0, pout}, 1);
        cnt = 0; ovf = 1; tick();
        check("R6 transfer on overflow", {16'd0, rd_val}, 8);
        cnt = 8; tick();
        check("R6 clear on match", {31'd0, pout}, 0);

        // constrained random phase
        for (int i = 0; i < 4000; i++) begin
            cnt = W'($urandom_range(0, 15));
            ovf = ($urandom_range(0, 3) == 0);
            clr = ($urandom_range(0, 7) == 0);
            if ($urandom_range(0, 3) == 0) pin = ~pin;
            if ($urandom_range(0, 15) == 0) begin
                cfg_wr = 1; cfg_wd = 4'($urandom_range(0, 15));
            end else if ($urandom_range(0, 5) == 0) begin
                val_wr = 1; val_wd = W'($urandom_range(0, 15));
            end
            tick();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule